// File: doc/BRIEF.md
# Parallel Converter Bus Controller

This block is the digital control side of an 8-bit converter that sits on a parallel microprocessor bus. A bus master talks to it through an active-low chip select, read and write strobes, and a static mode input. A stand-in for the analog core is built in. A down-counter measures a fixed conversion time in system clocks. At the end of that time the value on the `sample` input, and the comparison bit on `over_ref`, are taken as the result.

Two bus modes exist. In read-only mode (mode low), a falling read strobe starts a conversion. The result goes onto the bus once it is ready, and an open-drain ready line holds the master off until then. In write-then-read mode (mode high), a rising write strobe starts the conversion, and a later read fetches the latched result. In both modes an active-low interrupt reports completion, and an active-low overflow output stays driven at all times. The tri-state data bus is modelled as a value plus a drive enable. All bus inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `adc_bus_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `data_drive` is 0, `int_n` is 1, `ofl_n` is 1 and `rdy_pull` is 0.
- R2: A read or write strobe has no effect while `cs_n` is high: no conversion starts, `int_n` stays 1 and `rdy_pull` stays 0.
- R3: With `mode`=0 and `cs_n` low, a falling `rd_n` starts a conversion. `int_n` goes low exactly CONV_CYCLES+3 clocks after the strobe changes, and `data_out` then holds the `sample` value present at that clock.
- R4: With `mode`=0, `data_drive` is 0 during a conversion. It is 1 while `cs_n` and `rd_n` are both low and a finished result is latched.
- R5: With `mode`=1 and `cs_n` low, a rising `wr_n` starts a conversion. It has the same CONV_CYCLES+3 clock latency to `int_n` low and the same capture of `sample`.
- R6: With `mode`=1, `data_drive` is 1 only while `cs_n` and `rd_n` are both low, and it does not depend on conversion state.
- R7: With `mode`=0, `rdy_pull` becomes 1 three clocks after `cs_n` falls and returns to 0 at the end of the conversion. With `mode`=1, `rdy_pull` is always 0.
- R8: `int_n` is set low only by the end of a conversion. A rising read strobe while chip select is low clears it to 1.
- R9: `ofl_n` takes the inverse of `over_ref` at the end of each conversion and is valid whatever `data_drive` is. While `ofl_n` is 0, `data_out` reads all ones (8'hFF).
- R10: A start strobe that arrives while a conversion is running is ignored. The running conversion keeps its timing, and no second completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| mode | input | 1 | 0 selects read-only mode, 1 selects write-then-read mode |
| sample | input | 8 | Digital stand-in for the converted value |
| over_ref | input | 1 | 1 when the input is above the upper reference |
| data_out | output | 8 | Bus data value |
| data_drive | output | 1 | 1 when the data bus is driven, 0 for high impedance |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| rdy_pull | output | 1 | 1 when the open-drain ready line pulls low |
| ofl_n | output | 1 | Overflow flag, active low, always driven |

## Verification
The bound checker watches the following on every cycle:
- the all-ones readout under overflow;
- that the interrupt falls only on a completion event and clears after a read rising edge;
- that the bus is driven in write-then-read mode only under an active read;
- that the ready line is never pulled in write-then-read mode;
- that a running conversion is neither cut short nor restarted.

The exact latency from strobe to interrupt, the captured data values, the chip-select gating and the absence of a second completion after an ignored strobe are shown only by the bench scenarios. A scoreboard there matches each completion with the expected result and start cycle.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  // index of each strobe in the synchronizer vector
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_RD   = 1;
  localparam int unsigned IDX_WR   = 2;
  localparam int unsigned IDX_MODE = 3;
  localparam int unsigned NSTROBE  = 4;

  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic rose(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // active-low strobe gated by active-low chip select
  function automatic logic gate_n(input logic strobe_n, input logic sel_n);
    return strobe_n | sel_n;
  endfunction

endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] prev_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {DEPTH{IDLE[b]}};
      else        chain <= {chain[DEPTH-2:0], async_i[b]};
    end
    assign level_o[b] = chain[STAGES-1];
    assign prev_o[b]  = chain[STAGES];
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned CONV_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign accept_o = start_i & ~busy;
  assign done_o   = busy & (cnt == '0);
  assign busy_o   = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept_o) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          accept_i,
  input  logic          rd_rise_i,
  input  logic          cs_fall_i,
  input  logic          mode_i,
  input  logic          rd_low_i,
  input  logic [DW-1:0] sample_i,
  input  logic          over_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o,
  output logic          int_n_o,
  output logic          rdy_pull_o,
  output logic          ofl_n_o
);

  logic [DW-1:0] lat;
  logic          ofl, valid, irq_n, rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat   <= '0;
      ofl   <= 1'b0;
      valid <= 1'b0;
      irq_n <= 1'b1;
      rdy   <= 1'b0;
    end else begin
      if (done_i) begin
        lat   <= sample_i;
        ofl   <= over_i;
        valid <= 1'b1;
        irq_n <= 1'b0;
      end else begin
        if (accept_i)  valid <= 1'b0;
        if (rd_rise_i) irq_n <= 1'b1;
      end
      if (done_i)                   rdy <= 1'b0;
      else if (cs_fall_i && !mode_i) rdy <= 1'b1;
    end
  end

  assign data_o     = ofl ? {DW{1'b1}} : lat;
  assign drive_o    = rd_low_i & (mode_i | valid);
  assign int_n_o    = irq_n;
  assign rdy_pull_o = rdy & ~mode_i;
  assign ofl_n_o    = ~ofl;

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int unsigned DW          = 8,
  parameter int unsigned CONV_CYCLES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          mode,
  input  logic [DW-1:0] sample,
  input  logic          over_ref,
  output logic [DW-1:0] data_out,
  output logic          data_drive,
  output logic          int_n,
  output logic          rdy_pull,
  output logic          ofl_n
);
  import adc_bus_pkg::*;

  localparam logic [NSTROBE-1:0] IDLE = 4'b0111;

  logic [NSTROBE-1:0] raw, lvl, prv;
  logic cs_s, rd_s, mode_s;
  logic rd_eff, rd_eff_p, wr_eff, wr_eff_p;
  logic rd_fall, rd_rise, wr_rise, cs_fall, start_edge;
  logic conv_accept, conv_busy, conv_done;

  assign raw[IDX_CS]   = cs_n;
  assign raw[IDX_RD]   = rd_n;
  assign raw[IDX_WR]   = wr_n;
  assign raw[IDX_MODE] = mode;

  adc_strobe_sync #(.N(NSTROBE), .STAGES(2), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .level_o(lvl), .prev_o(prv)
  );

  assign cs_s     = lvl[IDX_CS];
  assign rd_s     = lvl[IDX_RD];
  assign mode_s   = lvl[IDX_MODE];
  assign rd_eff   = gate_n(lvl[IDX_RD], lvl[IDX_CS]);
  assign rd_eff_p = gate_n(prv[IDX_RD], prv[IDX_CS]);
  assign wr_eff   = gate_n(lvl[IDX_WR], lvl[IDX_CS]);
  assign wr_eff_p = gate_n(prv[IDX_WR], prv[IDX_CS]);

  assign rd_fall    = fell(rd_eff_p, rd_eff);
  assign rd_rise    = rose(rd_eff_p, rd_eff);
  assign wr_rise    = rose(wr_eff_p, wr_eff);
  assign cs_fall    = fell(prv[IDX_CS], lvl[IDX_CS]);
  assign start_edge = mode_s ? wr_rise : rd_fall;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_edge),
    .accept_o(conv_accept), .busy_o(conv_busy), .done_o(conv_done)
  );

  adc_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .done_i(conv_done), .accept_i(conv_accept),
    .rd_rise_i(rd_rise), .cs_fall_i(cs_fall), .mode_i(mode_s),
    .rd_low_i(~rd_eff), .sample_i(sample), .over_i(over_ref),
    .data_o(data_out), .drive_o(data_drive), .int_n_o(int_n),
    .rdy_pull_o(rdy_pull), .ofl_n_o(ofl_n)
  );

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_s,
  input logic          cs_s,
  input logic          rd_s,
  input logic          rd_rise,
  input logic          start_edge,
  input logic          conv_busy,
  input logic          conv_done,
  input logic [DW-1:0] data_out,
  input logic          data_drive,
  input logic          int_n,
  input logic          rdy_pull,
  input logic          ofl_n
);

  a_r9_ofl_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!ofl_n) |-> (data_out == {DW{1'b1}}));

  a_r8_int_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(conv_done));

  a_r8_int_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !conv_done && !int_n) |=> int_n);

  a_r6_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && data_drive) |-> (!cs_s && !rd_s));

  a_r7_ready_rd_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pull |-> !mode_s);

  a_r4_no_drive_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && conv_busy) |-> !data_drive);

  a_r10_busy_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> conv_busy);

  a_r10_start_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> $past(start_edge));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .cs_s(cs_s), .rd_s(rd_s),
  .rd_rise(rd_rise), .start_edge(start_edge), .conv_busy(conv_busy),
  .conv_done(conv_done), .data_out(data_out), .data_drive(data_drive),
  .int_n(int_n), .rdy_pull(rdy_pull), .ofl_n(ofl_n)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;

  localparam int CONV = 12;
  localparam int LAT  = CONV + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode = 1'b0;
  logic [7:0] sample = 8'h00;
  logic       over_ref = 1'b0;
  logic [7:0] data_out;
  logic       data_drive, int_n, rdy_pull, ofl_n;

  always #10 clk = ~clk;

  adc_bus_ctrl #(.DW(8), .CONV_CYCLES(CONV)) u_adc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode(mode), .sample(sample), .over_ref(over_ref),
    .data_out(data_out), .data_drive(data_drive), .int_n(int_n),
    .rdy_pull(rdy_pull), .ofl_n(ofl_n)
  );

  typedef struct {
    logic [7:0] d;
    logic       of_n;
    int         t;
    string      req;
  } item_t;

  item_t sbq[$];
  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  logic  finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] s, input logic o, input string req);
    item_t it;
    it.d    = o ? 8'hFF : s;
    it.of_n = ~o;
    it.t    = cyc;
    it.req  = req;
    sbq.push_back(it);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 60000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor: pops one expected item per completion
  logic prev_int = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_int && !int_n) begin
        if (sbq.size() == 0) begin
          chk("R10 unexpected completion", 1, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk({it.req, " data"}, data_out, it.d);
          chk({it.req, " R9 ofl"}, ofl_n, it.of_n);
          chk({it.req, " latency"}, cyc - it.t, LAT);
        end
      end
      prev_int = int_n;
    end
  end

  task automatic wait_int();
    while (int_n) @(negedge clk);
  endtask

  task automatic rd_conv(input logic [7:0] s, input logic o);
    @(negedge clk);
    sample = s; over_ref = o; cs_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b0;
    push(s, o, "R3");
    repeat (6) @(negedge clk);
    chk("R7 ready pulled", rdy_pull, 1);
    chk("R4 no drive busy", data_drive, 0);
    wait_int();
    chk("R4 drive after done", data_drive, 1);
    @(negedge clk);
    chk("R7 ready released", rdy_pull, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 int cleared", int_n, 1);
    chk("R4 drive off", data_drive, 0);
  endtask

  task automatic wr_conv(input logic [7:0] s, input logic o);
    @(negedge clk);
    sample = s; over_ref = o; cs_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    push(s, o, "R5");
    wait_int();
    chk("R6 no drive without read", data_drive, 0);
    chk("R7 ready unused", rdy_pull, 0);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 drive on read", data_drive, 1);
    chk("R5 read data", data_out, o ? 8'hFF : s);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 int cleared", int_n, 1);
    chk("R6 drive off", data_drive, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 drive", data_drive, 0);
    chk("R1 int", int_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ofl", ofl_n, 1);
    chk("R1 ready", rdy_pull, 0);

    // read-only mode
    rd_conv(8'h5A, 1'b0);
    rd_conv(8'h13, 1'b1);
    chk("R9 ofl held undriven bus", ofl_n, 0);
    chk("R9 all ones", data_out, 8'hFF);
    rd_conv(8'hA7, 1'b0);

    // chip select high gates the strobes
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    repeat (LAT + 5) @(negedge clk);
    chk("R2 no start on read", int_n, 1);
    chk("R2 no ready", rdy_pull, 0);

    // write-then-read mode
    mode = 1'b1;
    repeat (4) @(negedge clk);
    wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (LAT + 5) @(negedge clk);
    chk("R2 no start on write", int_n, 1);
    wr_conv(8'hC3, 1'b0);
    wr_conv(8'h01, 1'b1);
    wr_conv(8'h00, 1'b0);

    // second start while busy is ignored
    @(negedge clk);
    sample = 8'h6E; over_ref = 1'b0; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    push(8'h6E, 1'b0, "R10");
    repeat (4) @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    wait_int();
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (LAT + 8) @(negedge clk);
    chk("R10 no second completion", int_n, 1);
    chk("R10 scoreboard empty", sbq.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule